// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital timing controller of an integrating analog-to-digital converter. A prescaler divides the input clock by four into internal ticks. Each conversion is a fixed frame of 1280 ticks, in three phases. The first 256 ticks zero the analog path. The next 256 ticks integrate the unknown input. The last 768 ticks deintegrate against a reference. Because the integrate window is fixed, choosing the input clock so that 256 ticks span whole periods of mains hum removes that hum from the result. The analog switches sit outside the block. The block drives three one-hot phase outputs and a reference-select output that tell those switches what to do.

The comparator arrives as a single synchronous bit. Its value on the last integrate tick gives the sign of the input. That sign also selects which reference is applied during deintegration. The block then counts deintegrate ticks until the comparator moves away from that sign. If the comparator never moves within the window, the result is flagged as overrange.

The magnitude, sign and overrange flag are loaded into the output register only when a conversion ends. Conversions start on a start request while idle (demand mode), or back to back (continuous mode). A busy output covers each conversion, and its falling edge can serve as an end-of-conversion interrupt.

Top module: `dslope_seq`

## Requirements
- R1: While `rst_i` is high at a clock edge, the block goes idle after that edge: `busy_o`, all phase outputs, `ref_neg_o`, `mag_o`, `pol_o` and `ovr_o` are all 0.
- R2: With the block idle and `start_i` high at a clock edge, `busy_o` is 1 after that edge. It then stays high for exactly 5120 input clocks (1280 ticks of 4 clocks each).
- R3: Count input clocks from the start edge. `az_o` is high for clocks 0 to 1023 of a conversion, `integ_o` for clocks 1024 to 2047, and `deint_o` for clocks 2048 to 5119. Exactly one phase output is high while busy, and none is high while idle.
- R4: The value of `cmp_i` on the final integrate tick (clock edge 2048) becomes the polarity. `ref_neg_o` shows the polarity during deintegration, and `pol_o` takes it at end of conversion.
- R5: The deintegrate ticks fall on edges 2048+4j, for j = 1 to 768. `mag_o` holds the number of these ticks at which `cmp_i` still equalled the polarity before the first one where it differed, and `ovr_o` is 0 in that case.
- R6: If `cmp_i` equals the polarity at all 768 deintegrate ticks, the conversion ends with `ovr_o` = 1 and `mag_o` = 768.
- R7: `mag_o`, `pol_o` and `ovr_o` keep their values throughout a conversion and change only on the edge where `busy_o` falls.
- R8: A `start_i` pulse while `busy_o` is high is ignored: the running conversion still ends exactly 5120 clocks after it began.
- R9: With `cont_i` high, a new conversion begins one clock after `busy_o` falls, with no start request, so `busy_o` is low for exactly one clock between conversions. With `cont_i` low and `start_i` low, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input (oscillator) clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cont_i | input | 1 | 1 = continuous conversions, 0 = demand mode |
| start_i | input | 1 | Start request, acted on only while idle |
| cmp_i | input | 1 | Synchronous comparator output |
| busy_o | output | 1 | High while a conversion is running |
| az_o | output | 1 | Auto-zero phase select |
| integ_o | output | 1 | Signal-integrate phase select |
| deint_o | output | 1 | Reference-deintegrate phase select |
| ref_neg_o | output | 1 | Reference polarity select (sampled polarity) |
| mag_o | output | 15 | Result magnitude in deintegrate ticks |
| pol_o | output | 1 | Result polarity |
| ovr_o | output | 1 | Result overrange flag |

## Verification
Conversions are run with the comparator crossing after 0, 100, 300 and 767 deintegrate ticks, and with no crossing at all. These cases separate an off-by-one count at either end of the window from a correct count, and the last one shows the overrange path. Both comparator polarities are used, so a design that ignores the sampled sign, or compares against a fixed level, gives a wrong count. The phase boundaries and the busy length are checked clock by clock. A start pulse in the middle of a conversion shows whether the frame restarts. A continuous pair shows the one-clock gap between conversions and the return to idle once continuous mode is dropped.

// File: rtl/dslope_seq_pkg.sv
package dslope_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_AZ    = 2'd1,
    PH_INT   = 2'd2,
    PH_DEINT = 2'd3
  } phase_t;
endpackage

// File: rtl/dslope_prescaler.sv
module dslope_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/dslope_frame_timer.sv
module dslope_frame_timer
  import dslope_seq_pkg::*;
#(
  parameter int AZ_TICKS    = 256,
  parameter int INT_TICKS   = 256,
  parameter int DEINT_TICKS = 768
) (
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   launch_i,
  input  logic   tick_i,
  output logic   busy_o,
  output phase_t phase_o,
  output logic   int_end_o,
  output logic   deint_tick_o,
  output logic   last_tick_o
);
  localparam int FRAME   = AZ_TICKS + INT_TICKS + DEINT_TICKS;
  localparam int CNT_W   = $clog2(FRAME);
  localparam int INT_LO  = AZ_TICKS;
  localparam int DEI_LO  = AZ_TICKS + INT_TICKS;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  phase_t           phase_q, phase_d;

  assign last_tick_o  = tick_i && (cnt_q == CNT_W'(FRAME - 1));
  assign int_end_o    = tick_i && (cnt_q == CNT_W'(DEI_LO - 1));
  assign deint_tick_o = tick_i && (cnt_q >= CNT_W'(DEI_LO));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (launch_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (tick_i) begin
      if (last_tick_o) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (!busy_d) begin
      phase_d = PH_IDLE;
    end else if (cnt_d < CNT_W'(INT_LO)) begin
      phase_d = PH_AZ;
    end else if (cnt_d < CNT_W'(DEI_LO)) begin
      phase_d = PH_INT;
    end else begin
      phase_d = PH_DEINT;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      phase_q <= PH_IDLE;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      phase_q <= phase_d;
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dslope_deint_counter.sv
module dslope_deint_counter #(
  parameter int DEINT_TICKS = 768,
  parameter int MAG_W       = 15
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             launch_i,
  input  logic             int_end_i,
  input  logic             deint_tick_i,
  input  logic             last_tick_i,
  input  logic             cmp_i,
  output logic             ref_neg_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             pol_o,
  output logic             ovr_o
);
  logic             sign_q;
  logic             crossed_q, crossed_d;
  logic [MAG_W-1:0] cnt_q, cnt_d;
  logic [MAG_W-1:0] mag_q;
  logic             pol_q, ovr_q;

  always_comb begin
    crossed_d = crossed_q;
    cnt_d     = cnt_q;
    if (launch_i) begin
      crossed_d = 1'b0;
      cnt_d     = '0;
    end else if (deint_tick_i && !crossed_q) begin
      if (cmp_i != sign_q) begin
        crossed_d = 1'b1;
      end else if (cnt_q < MAG_W'(DEINT_TICKS)) begin
        cnt_d = cnt_q + MAG_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sign_q    <= 1'b0;
      crossed_q <= 1'b0;
      cnt_q     <= '0;
      mag_q     <= '0;
      pol_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      crossed_q <= crossed_d;
      cnt_q     <= cnt_d;
      if (int_end_i) begin
        sign_q <= cmp_i;
      end
      if (last_tick_i) begin
        mag_q <= cnt_d;
        pol_q <= sign_q;
        ovr_q <= !crossed_d;
      end
    end
  end

  assign ref_neg_o = sign_q;
  assign mag_o     = mag_q;
  assign pol_o     = pol_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_seq_pkg::*;
#(
  parameter int PRE_DIV     = 4,
  parameter int AZ_TICKS    = 256,
  parameter int INT_TICKS   = 256,
  parameter int DEINT_TICKS = 768,
  parameter int MAG_W       = 15
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cont_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             az_o,
  output logic             integ_o,
  output logic             deint_o,
  output logic             ref_neg_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             pol_o,
  output logic             ovr_o
);
  logic   busy;
  logic   tick;
  logic   launch;
  logic   int_end;
  logic   deint_tick;
  logic   last_tick;
  phase_t phase;

  assign launch = !busy && (start_i || cont_i);

  dslope_prescaler #(
    .DIV (PRE_DIV)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (busy),
    .tick_o (tick)
  );

  dslope_frame_timer #(
    .AZ_TICKS    (AZ_TICKS),
    .INT_TICKS   (INT_TICKS),
    .DEINT_TICKS (DEINT_TICKS)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .launch_i     (launch),
    .tick_i       (tick),
    .busy_o       (busy),
    .phase_o      (phase),
    .int_end_o    (int_end),
    .deint_tick_o (deint_tick),
    .last_tick_o  (last_tick)
  );

  dslope_deint_counter #(
    .DEINT_TICKS (DEINT_TICKS),
    .MAG_W       (MAG_W)
  ) u_count (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .launch_i     (launch),
    .int_end_i    (int_end),
    .deint_tick_i (deint_tick),
    .last_tick_i  (last_tick),
    .cmp_i        (cmp_i),
    .ref_neg_o    (ref_neg_o),
    .mag_o        (mag_o),
    .pol_o        (pol_o),
    .ovr_o        (ovr_o)
  );

  assign busy_o  = busy;
  assign az_o    = (phase == PH_AZ);
  assign integ_o = (phase == PH_INT);
  assign deint_o = (phase == PH_DEINT);
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int PRE_DIV     = 4,
  parameter int AZ_TICKS    = 256,
  parameter int INT_TICKS   = 256,
  parameter int DEINT_TICKS = 768,
  parameter int MAG_W       = 15
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             cont_i,
  input logic             busy_o,
  input logic             az_o,
  input logic             integ_o,
  input logic             deint_o,
  input logic             ref_neg_o,
  input logic [MAG_W-1:0] mag_o,
  input logic             pol_o,
  input logic             ovr_o
);
  localparam int CONV_CLKS = (AZ_TICKS + INT_TICKS + DEINT_TICKS) * PRE_DIV;

  int busy_len;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_len <= 0;
    end else if (busy_o) begin
      busy_len <= busy_len + 1;
    end else begin
      busy_len <= 0;
    end
  end

  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> (busy_len < CONV_CLKS)); // R2
  AST_BUSY_EXACT: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> (busy_len == CONV_CLKS)); // R2
  AST_PHASE_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> $onehot({az_o, integ_o, deint_o})); // R3
  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> ({az_o, integ_o, deint_o} == 3'b000)); // R3
  AST_POL_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> (pol_o == ref_neg_o)); // R4
  AST_MAG_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    mag_o <= MAG_W'(DEINT_TICKS)); // R5
  AST_OVR_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
    ovr_o |-> (mag_o == MAG_W'(DEINT_TICKS))); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && $past(busy_o)) |-> ($stable(mag_o) && $stable(pol_o) && $stable(ovr_o))); // R7
  AST_CONT_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (cont_i && $fell(busy_o)) |=> busy_o); // R9
endmodule

bind dslope_seq dslope_seq_chk #(
  .PRE_DIV     (PRE_DIV),
  .AZ_TICKS    (AZ_TICKS),
  .INT_TICKS   (INT_TICKS),
  .DEINT_TICKS (DEINT_TICKS),
  .MAG_W       (MAG_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cont_i    (cont_i),
  .busy_o    (busy_o),
  .az_o      (az_o),
  .integ_o   (integ_o),
  .deint_o   (deint_o),
  .ref_neg_o (ref_neg_o),
  .mag_o     (mag_o),
  .pol_o     (pol_o),
  .ovr_o     (ovr_o)
);

// File: tb/dslope_seq_tb_top.sv
module dslope_seq_tb_top;
  localparam int CONV = 5120;
  localparam int DEI0 = 2048;
  localparam int WIN  = 768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cont = 1'b0;
  logic        start = 1'b0;
  logic        cmp = 1'b0;
  logic        busy, az, integ, deint, ref_neg, pol, ovr;
  logic [14:0] mag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dslope_seq dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .cont_i    (cont),
    .start_i   (start),
    .cmp_i     (cmp),
    .busy_o    (busy),
    .az_o      (az),
    .integ_o   (integ),
    .deint_o   (deint),
    .ref_neg_o (ref_neg),
    .mag_o     (mag),
    .pol_o     (pol),
    .ovr_o     (ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one conversion starting at k=0 (the negedge after the start edge).
  task automatic run_loop(input int n, input bit p, input bit inject);
    int bad_busy = 0;
    int bad_phase = 0;
    int bad_hold = 0;
    logic [14:0] m0 = mag;
    logic p0 = pol;
    logic o0 = ovr;
    int exp_mag = (n < WIN) ? n : WIN;
    for (int k = 0; k <= CONV; k++) begin
      if (k == 0) cmp = p;
      if (n < WIN && k == DEI0 + 4 * n) cmp = ~p;
      if (inject && k == 100) start = 1'b1;
      if (inject && k == 101) start = 1'b0;
      if (k < CONV) begin
        if (busy !== 1'b1) bad_busy++;
        if (az !== (k < 1024) || integ !== (k >= 1024 && k < DEI0) ||
            deint !== (k >= DEI0)) bad_phase++;
        if (mag !== m0 || pol !== p0 || ovr !== o0) bad_hold++;
        if (k == 3000) chk(ref_neg === p, "R4 ref_neg", int'(ref_neg), int'(p));
        @(negedge clk);
      end
    end
    chk(bad_busy == 0, inject ? "R8 busy held" : "R2 busy held", bad_busy, 0);
    chk(busy === 1'b0, inject ? "R8 busy end" : "R2 busy end", int'(busy), 0);
    chk(bad_phase == 0, "R3 phase timing", bad_phase, 0);
    chk({az, integ, deint} === 3'b000, "R3 idle phases", int'({az, integ, deint}), 0);
    chk(bad_hold == 0, "R7 result hold", bad_hold, 0);
    chk(pol === p, "R4 polarity", int'(pol), int'(p));
    chk(mag === 15'(exp_mag), (n < WIN) ? "R5 magnitude" : "R6 magnitude", int'(mag), exp_mag);
    chk(ovr === (n >= WIN), (n < WIN) ? "R5 overrange" : "R6 overrange", int'(ovr), int'(n >= WIN));
  endtask

  task automatic t_demand(input int n, input bit p, input bit inject);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy rise", int'(busy), 1);
    run_loop(n, p, inject);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk({az, integ, deint, ref_neg} === 4'b0000, "R1 phases", int'({az, integ, deint, ref_neg}), 0);
    chk(mag === 15'd0 && pol === 1'b0 && ovr === 1'b0, "R1 result", int'({ovr, pol, mag}), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle();
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R9 demand idle", int'(busy), 0);
  endtask

  task automatic t_continuous();
    cont = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b1, "R9 cont start", int'(busy), 1);
    run_loop(50, 1'b0, 1'b0);
    @(negedge clk);
    chk(busy === 1'b1, "R9 cont restart", int'(busy), 1);
    cont = 1'b0;
    run_loop(600, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(busy === 1'b0, "R9 cont stop", int'(busy), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_demand(100, 1'b0, 1'b0);
    t_demand(0, 1'b1, 1'b0);
    t_demand(767, 1'b0, 1'b0);
    t_demand(WIN, 1'b1, 1'b0);
    t_demand(300, 1'b1, 1'b1);
    t_continuous();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule